// File: doc/BRIEF.md
# Nonvolatile Memory Read-Error Flag and Interrupt Unit

This block sits beside a nonvolatile memory controller and gathers its error reports into sticky status flags and a single interrupt line. On every array read the controller presents a read strobe together with single-bit and double-bit ECC detect indications, the address that was read and the data word that came back. The controller also sends failure pulses from emulated-EEPROM program and erase operations, and a pulse when a write to the buffer RAM partition breaks its protection.

Software controls the unit through two registers. The first is an 8-bit interrupt-enable register. The second is a small injection register with two force bits. While a force bit is set, every array read raises the matching ECC flag, so the interrupt handler can be exercised without a real fault. The capture register still records only genuine faults. It holds the address and data of the first real fault, and a double-bit fault takes the place of a single-bit record. Flags are cleared by writing 1 to them. The interrupt is a registered OR of every flag whose enable is set.

Top module: `nvm_fault_unit`

## Requirements
- R1: The enable register resets to 0x00 and reads back what was written, except bit 5, which always reads 0 and ignores writes. Bit mapping: 7 erase-error enable, 6 program-error enable, 4 protection enable, 3:2 erase-verify enables (stored only), 1 double-fault enable, 0 single-fault enable.
- R2: The injection register resets to 0. Bit 1 forces double faults and bit 0 forces single faults. Each bit stays set across any number of reads until software writes 0 to it. Bits 7:2 read 0.
- R3: Status bits are: 0 single-bit fault, 1 double-bit fault, 2 protection violation, 3 program error, 4 erase error, 7:5 zero. With both force bits clear, bit 0 or bit 1 sets only when the read strobe coincides with the matching genuine detect. A detect input without the read strobe has no effect.
- R4: While force-single is set, every read strobe sets status bit 0.
- R5: While force-double is set, every read strobe sets status bit 1.
- R6: The capture register loads only on a genuine detect during a read strobe. A read whose flag is raised only by a force bit leaves the capture register unchanged.
- R7: Once valid, the capture register keeps its address, data and type until the status flag of the captured type is cleared. A later genuine fault of the same type is not recorded.
- R8: A genuine double-bit fault replaces a single-bit capture. If both detects arrive on one read, the double-bit fault is the one recorded.
- R9: Program-failure, erase-failure and protection-violation pulses set status bits 3, 4 and 2 respectively.
- R10: Writing 1 to a status bit clears it. If a new event for that bit arrives in the same cycle as the clear, the bit stays set.
- R11: The interrupt output is the registered OR of the five flag and enable pairs. It changes one cycle after the flags or enables change, and the erase-verify enable bits never drive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ie_wr | input | 1 | Write strobe for the enable register |
| ie_wdata | input | 8 | Enable register write data |
| ie_rdata | output | 8 | Enable register read value |
| inj_wr | input | 1 | Write strobe for the injection register |
| inj_wdata | input | 8 | Injection register write data |
| inj_rdata | output | 8 | Injection register read value |
| st_clr | input | 1 | Status write-one-to-clear strobe |
| st_clr_mask | input | 8 | Bits of status to clear |
| st_rdata | output | 8 | Status flags |
| rd_stb | input | 1 | One array read completes this cycle |
| ecc_sgl | input | 1 | Genuine single-bit fault on this read |
| ecc_dbl | input | 1 | Genuine double-bit fault on this read |
| rd_addr | input | ADDR_W | Address of the read |
| rd_data | input | DATA_W | Data word of the read |
| ee_pgm_fail | input | 1 | Emulated-EEPROM program failure pulse |
| ee_ers_fail | input | 1 | Emulated-EEPROM erase failure pulse |
| prot_viol | input | 1 | Buffer RAM protection violation pulse |
| cap_valid | output | 1 | Capture register holds a fault |
| cap_dbl | output | 1 | Captured fault is double-bit |
| cap_addr | output | ADDR_W | Captured address |
| cap_data | output | DATA_W | Captured data |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench checks that force bits raise flags on reads with no real fault while the capture register stays empty. A design that loaded the capture on forced flags would show a valid capture with no fault behind it. It checks that a second single fault cannot overwrite the first capture, that a double fault does replace it, and that clearing the wrong flag does not free the capture. A same-cycle clear and new event must leave the flag set, so a design where the clear wins would drop that event. It also confirms that the erase-verify enables never raise the interrupt and that the interrupt falls exactly one cycle after the last flag clears.

// File: rtl/nvm_fault_pkg.sv
package nvm_fault_pkg;

    localparam int NFLAG = 5;

    // enable register bit positions
    localparam int IE_ERS  = 7;
    localparam int IE_PGM  = 6;
    localparam int IE_RSVD = 5;
    localparam int IE_PROT = 4;
    localparam int IE_DBL  = 1;
    localparam int IE_SGL  = 0;

    // injection register bit positions
    localparam int INJ_DBL = 1;
    localparam int INJ_SGL = 0;

    // sticky flag set, LSB first: sgl, dbl, prot, pgm, ers
    typedef struct packed {
        logic ers;
        logic pgm;
        logic prot;
        logic dbl;
        logic sgl;
    } flags_t;

    typedef struct packed {
        logic [7:0] ie;
        logic       frc_dbl;
        logic       frc_sgl;
    } ctl_t;

    function automatic flags_t enables_of(input logic [7:0] ie);
        flags_t e;
        e.ers  = ie[IE_ERS];
        e.pgm  = ie[IE_PGM];
        e.prot = ie[IE_PROT];
        e.dbl  = ie[IE_DBL];
        e.sgl  = ie[IE_SGL];
        return e;
    endfunction

    function automatic logic [7:0] widen_flags(input flags_t f);
        return {{(8 - NFLAG){1'b0}}, f};
    endfunction

endpackage

// File: rtl/nvm_fault_ctl.sv
module nvm_fault_ctl
    import nvm_fault_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ie_wr,
    input  logic [7:0] ie_wdata,
    input  logic       inj_wr,
    input  logic [7:0] inj_wdata,
    output ctl_t       ctl,
    output logic [7:0] ie_rdata,
    output logic [7:0] inj_rdata
);
    localparam logic [7:0] IE_MASK = ~(8'h01 << IE_RSVD);

    logic [7:0] ie_q;
    logic       fd_q, fs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= '0;
        end else if (ie_wr) begin
            ie_q <= ie_wdata & IE_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fd_q <= 1'b0;
            fs_q <= 1'b0;
        end else if (inj_wr) begin
            fd_q <= inj_wdata[INJ_DBL];
            fs_q <= inj_wdata[INJ_SGL];
        end
    end

    always_comb begin
        ctl.ie      = ie_q;
        ctl.frc_dbl = fd_q;
        ctl.frc_sgl = fs_q;
        ie_rdata    = ie_q;
        inj_rdata   = '0;
        inj_rdata[INJ_DBL] = fd_q;
        inj_rdata[INJ_SGL] = fs_q;
    end
endmodule

// File: rtl/nvm_fault_flags.sv
module nvm_fault_flags
    import nvm_fault_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t set_v,
    input  flags_t clr_v,
    output flags_t flags
);
    logic [NFLAG-1:0] set_b, clr_b, q_b;

    assign set_b = set_v;
    assign clr_b = clr_v;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                q_b[i] <= 1'b0;
            end else if (set_b[i]) begin
                q_b[i] <= 1'b1;
            end else if (clr_b[i]) begin
                q_b[i] <= 1'b0;
            end
        end
    end

    assign flags = q_b;
endmodule

// File: rtl/nvm_fault_capture.sv
module nvm_fault_capture #(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stb,
    input  logic              ecc_sgl,
    input  logic              ecc_dbl,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              clr_sgl,
    input  logic              clr_dbl,
    output logic              cap_valid,
    output logic              cap_dbl,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    logic gen_d, gen_s, release_c, free_c, load_d, load_s;

    always_comb begin
        gen_d     = rd_stb & ecc_dbl;
        gen_s     = rd_stb & ecc_sgl;
        release_c = cap_valid & (cap_dbl ? clr_dbl : clr_sgl);
        free_c    = ~cap_valid | release_c;
        load_d    = gen_d & (free_c | ~cap_dbl);
        load_s    = ~gen_d & gen_s & free_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_valid <= 1'b0;
            cap_dbl   <= 1'b0;
            cap_addr  <= '0;
            cap_data  <= '0;
        end else if (load_d | load_s) begin
            cap_valid <= 1'b1;
            cap_dbl   <= load_d;
            cap_addr  <= rd_addr;
            cap_data  <= rd_data;
        end else if (release_c) begin
            cap_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/nvm_fault_irq.sv
module nvm_fault_irq
    import nvm_fault_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t flags,
    input  flags_t enables,
    output logic   irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= |(flags & enables);
        end
    end
endmodule

// File: rtl/nvm_fault_unit.sv
module nvm_fault_unit
    import nvm_fault_pkg::*;
#(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ie_wr,
    input  logic [7:0]        ie_wdata,
    output logic [7:0]        ie_rdata,
    input  logic              inj_wr,
    input  logic [7:0]        inj_wdata,
    output logic [7:0]        inj_rdata,
    input  logic              st_clr,
    input  logic [7:0]        st_clr_mask,
    output logic [7:0]        st_rdata,
    input  logic              rd_stb,
    input  logic              ecc_sgl,
    input  logic              ecc_dbl,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              ee_pgm_fail,
    input  logic              ee_ers_fail,
    input  logic              prot_viol,
    output logic              cap_valid,
    output logic              cap_dbl,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic              irq
);
    ctl_t   ctl;
    flags_t set_v, clr_v, flags, enables;

    nvm_fault_ctl u_ctl (
        .clk       (clk),
        .rst       (rst),
        .ie_wr     (ie_wr),
        .ie_wdata  (ie_wdata),
        .inj_wr    (inj_wr),
        .inj_wdata (inj_wdata),
        .ctl       (ctl),
        .ie_rdata  (ie_rdata),
        .inj_rdata (inj_rdata)
    );

    always_comb begin
        set_v.sgl  = rd_stb & (ecc_sgl | ctl.frc_sgl);
        set_v.dbl  = rd_stb & (ecc_dbl | ctl.frc_dbl);
        set_v.prot = prot_viol;
        set_v.pgm  = ee_pgm_fail;
        set_v.ers  = ee_ers_fail;
        clr_v      = st_clr ? flags_t'(st_clr_mask[NFLAG-1:0]) : '0;
        enables    = enables_of(ctl.ie);
    end

    nvm_fault_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_v (set_v),
        .clr_v (clr_v),
        .flags (flags)
    );

    assign st_rdata = widen_flags(flags);

    nvm_fault_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .rd_stb    (rd_stb),
        .ecc_sgl   (ecc_sgl),
        .ecc_dbl   (ecc_dbl),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .clr_sgl   (clr_v.sgl),
        .clr_dbl   (clr_v.dbl),
        .cap_valid (cap_valid),
        .cap_dbl   (cap_dbl),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data)
    );

    nvm_fault_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .flags   (flags),
        .enables (enables),
        .irq     (irq)
    );
endmodule

// File: rtl/nvm_fault_unit_chk.sv
module nvm_fault_unit_chk #(
    parameter int ADDR_W = 23,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        ie_rdata,
    input logic [7:0]        inj_rdata,
    input logic              inj_wr,
    input logic [7:0]        inj_wdata,
    input logic              st_clr,
    input logic [7:0]        st_clr_mask,
    input logic [7:0]        st_rdata,
    input logic              rd_stb,
    input logic              ecc_sgl,
    input logic              ecc_dbl,
    input logic              ee_pgm_fail,
    input logic              cap_valid,
    input logic              cap_dbl,
    input logic [ADDR_W-1:0] cap_addr,
    input logic              irq
);
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        ie_rdata[5] == 1'b0);

    p_inj_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        inj_rdata[7:2] == 6'b0);

    p_force_hold_r2: assert property (@(posedge clk) disable iff (rst)
        inj_rdata[0] && !inj_wr |=> inj_rdata[0]);

    p_force_sgl_r4: assert property (@(posedge clk) disable iff (rst)
        rd_stb && inj_rdata[0] |=> st_rdata[0]);

    p_force_dbl_r5: assert property (@(posedge clk) disable iff (rst)
        rd_stb && inj_rdata[1] |=> st_rdata[1]);

    p_capture_genuine_r6: assert property (@(posedge clk) disable iff (rst)
        cap_valid && !$stable(cap_addr) |-> $past(rd_stb && (ecc_sgl || ecc_dbl)));

    p_double_wins_r8: assert property (@(posedge clk) disable iff (rst)
        rd_stb && ecc_dbl |=> cap_valid && cap_dbl);

    p_pgm_set_r9: assert property (@(posedge clk) disable iff (rst)
        ee_pgm_fail |=> st_rdata[3]);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        rd_stb && ecc_sgl |=> st_rdata[0]);

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        st_rdata[1] && !(st_clr && st_clr_mask[1]) |=> st_rdata[1]);

    p_irq_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        st_rdata == 8'h00 |=> !irq);

    always_comb begin
        if (!rst) begin
            p_status_upper_r3: assert (st_rdata[7:5] == 3'b0);
        end
    end
endmodule

bind nvm_fault_unit nvm_fault_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ie_rdata    (ie_rdata),
    .inj_rdata   (inj_rdata),
    .inj_wr      (inj_wr),
    .inj_wdata   (inj_wdata),
    .st_clr      (st_clr),
    .st_clr_mask (st_clr_mask),
    .st_rdata    (st_rdata),
    .rd_stb      (rd_stb),
    .ecc_sgl     (ecc_sgl),
    .ecc_dbl     (ecc_dbl),
    .ee_pgm_fail (ee_pgm_fail),
    .cap_valid   (cap_valid),
    .cap_dbl     (cap_dbl),
    .cap_addr    (cap_addr),
    .irq         (irq)
);

// File: tb/nvm_fault_unit_test.sv
`timescale 1ns/1ps
module nvm_fault_unit_test;
    localparam int AW = 23;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ie_wr = 0, inj_wr = 0, st_clr = 0;
    logic [7:0]    ie_wdata = 0, inj_wdata = 0, st_clr_mask = 0;
    logic          rd_stb = 0, ecc_sgl = 0, ecc_dbl = 0;
    logic [AW-1:0] rd_addr = 0;
    logic [DW-1:0] rd_data = 0;
    logic          ee_pgm_fail = 0, ee_ers_fail = 0, prot_viol = 0;
    logic [7:0]    ie_rdata, inj_rdata, st_rdata;
    logic          cap_valid, cap_dbl, irq;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;

    always #10 clk = ~clk;

    nvm_fault_unit #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .ie_wr(ie_wr), .ie_wdata(ie_wdata), .ie_rdata(ie_rdata),
        .inj_wr(inj_wr), .inj_wdata(inj_wdata), .inj_rdata(inj_rdata),
        .st_clr(st_clr), .st_clr_mask(st_clr_mask), .st_rdata(st_rdata),
        .rd_stb(rd_stb), .ecc_sgl(ecc_sgl), .ecc_dbl(ecc_dbl),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ee_pgm_fail(ee_pgm_fail), .ee_ers_fail(ee_ers_fail), .prot_viol(prot_viol),
        .cap_valid(cap_valid), .cap_dbl(cap_dbl), .cap_addr(cap_addr),
        .cap_data(cap_data), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done   = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    int unsigned m_ie, m_inj, m_st, m_irq, m_cv, m_cd, m_ca, m_cdat;

    function automatic int unsigned en_mask(input int unsigned ie);
        int unsigned e = 0;
        if (ie & 8'h01) e |= 1;
        if (ie & 8'h02) e |= 2;
        if (ie & 8'h10) e |= 4;
        if (ie & 8'h40) e |= 8;
        if (ie & 8'h80) e |= 16;
        return e;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ie = 0; m_inj = 0; m_st = 0; m_irq = 0;
            m_cv = 0; m_cd = 0; m_ca = 0; m_cdat = 0;
        end else begin
            int unsigned sets, clrs, nst;
            bit freed, rel;
            m_irq = ((m_st & en_mask(m_ie)) != 0) ? 1 : 0;
            sets = 0;
            if (rd_stb && (ecc_sgl || (m_inj & 1))) sets |= 1;
            if (rd_stb && (ecc_dbl || (m_inj & 2))) sets |= 2;
            if (prot_viol)   sets |= 4;
            if (ee_pgm_fail) sets |= 8;
            if (ee_ers_fail) sets |= 16;
            clrs = st_clr ? (st_clr_mask & 8'h1F) : 0;
            nst  = (m_st & ~clrs) | sets;
            rel  = m_cv && (m_cd ? ((clrs & 2) != 0) : ((clrs & 1) != 0));
            freed = !m_cv || rel;
            if (rd_stb && ecc_dbl && (freed || !m_cd)) begin
                m_cv = 1; m_cd = 1; m_ca = rd_addr; m_cdat = rd_data;
            end else if (rd_stb && ecc_sgl && !ecc_dbl && freed) begin
                m_cv = 1; m_cd = 0; m_ca = rd_addr; m_cdat = rd_data;
            end else if (rel) begin
                m_cv = 0;
            end
            m_st = nst;
            if (ie_wr)  m_ie  = ie_wdata & 8'hDF;
            if (inj_wr) m_inj = inj_wdata & 8'h03;
        end
    end

    // cycle compare, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1 enable reg", ie_rdata, m_ie);
            chk("R2 inject reg", inj_rdata, m_inj);
            chk("R10 status", st_rdata, m_st);
            chk("R6 cap_valid", cap_valid, m_cv);
            if (m_cv != 0) begin
                chk("R8 cap_dbl", cap_dbl, m_cd);
                chk("R7 cap_addr", cap_addr, m_ca);
                chk("R7 cap_data", cap_data, m_cdat);
            end
            chk("R11 irq", irq, m_irq);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step();
        @(negedge clk);
    endtask

    task automatic w_ie(input logic [7:0] v);
        ie_wr = 1; ie_wdata = v; step(); ie_wr = 0;
    endtask

    task automatic w_inj(input logic [7:0] v);
        inj_wr = 1; inj_wdata = v; step(); inj_wr = 0;
    endtask

    task automatic w_clr(input logic [7:0] v);
        st_clr = 1; st_clr_mask = v; step(); st_clr = 0; st_clr_mask = 0;
    endtask

    task automatic rd(input bit s, input bit d, input logic [AW-1:0] a, input logic [DW-1:0] dat);
        rd_stb = 1; ecc_sgl = s; ecc_dbl = d; rd_addr = a; rd_data = dat;
        step();
        rd_stb = 0; ecc_sgl = 0; ecc_dbl = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 0;
        step();
        cmp_on = 1;
        // reset state
        chk("R1 reset ie", ie_rdata, 8'h00);
        chk("R2 reset inj", inj_rdata, 8'h00);
        chk("R3 reset status", st_rdata, 8'h00);
        chk("R11 reset irq", irq, 0);

        // R1 reserved bit
        w_ie(8'hFF);
        chk("R1 rsvd bit5", ie_rdata, 8'hDF);
        w_ie(8'h00);

        // R2 inject readback
        w_inj(8'hFF);
        chk("R2 inj upper zero", inj_rdata, 8'h03);
        w_inj(8'h00);
        chk("R2 inj cleared by 0", inj_rdata, 8'h00);

        // R3 genuine single, and detect without strobe
        rd(1, 0, 23'h00_1234, 16'hA5A5);
        chk("R3 single flag", st_rdata, 8'h01);
        chk("R6 capture single", cap_valid, 1);
        chk("R7 capture addr", cap_addr, 23'h00_1234);
        ecc_dbl = 1; step(); ecc_dbl = 0;
        chk("R3 no strobe no flag", st_rdata, 8'h01);

        // R7 second single ignored
        rd(1, 0, 23'h00_5555, 16'h1111);
        chk("R7 first kept addr", cap_addr, 23'h00_1234);
        chk("R7 first kept data", cap_data, 16'hA5A5);

        // R8 double overrides
        rd(0, 1, 23'h00_7777, 16'h2222);
        chk("R8 dbl override", cap_dbl, 1);
        chk("R8 dbl addr", cap_addr, 23'h00_7777);
        chk("R3 both flags", st_rdata, 8'h03);
        w_clr(8'h01);
        chk("R7 wrong clear keeps capture", cap_valid, 1);
        w_clr(8'h02);
        chk("R7 capture released", cap_valid, 0);
        chk("R10 w1c", st_rdata, 8'h00);

        // R8 both on one read
        rd(1, 1, 23'h00_0042, 16'h4242);
        chk("R8 both detects dbl", cap_dbl, 1);
        w_clr(8'h03);

        // R4 / R5 forcing, R6 no capture
        w_inj(8'h01);
        rd(0, 0, 23'h00_0100, 16'h0);
        chk("R4 forced single", st_rdata, 8'h01);
        chk("R6 forced no capture", cap_valid, 0);
        w_inj(8'h03);
        rd(0, 0, 23'h00_0200, 16'h0);
        rd(0, 0, 23'h00_0300, 16'h0);
        chk("R5 forced double", st_rdata, 8'h03);
        chk("R6 forced dbl no capture", cap_valid, 0);
        chk("R2 force holds", inj_rdata, 8'h03);
        w_inj(8'h00);
        w_clr(8'h03);
        rd(0, 0, 23'h00_0400, 16'h0);
        chk("R3 no force no flag", st_rdata, 8'h00);

        // R9 event pulses
        ee_pgm_fail = 1; step(); ee_pgm_fail = 0;
        chk("R9 program flag", st_rdata, 8'h08);
        ee_ers_fail = 1; step(); ee_ers_fail = 0;
        chk("R9 erase flag", st_rdata, 8'h18);
        prot_viol = 1; step(); prot_viol = 0;
        chk("R9 protection flag", st_rdata, 8'h1C);
        w_clr(8'hFF);

        // R10 set wins over clear
        rd(1, 0, 23'h00_0010, 16'h0010);
        st_clr = 1; st_clr_mask = 8'h01;
        rd(1, 0, 23'h00_0020, 16'h0020);
        st_clr = 0; st_clr_mask = 0;
        chk("R10 set beats clear", st_rdata, 8'h01);
        chk("R7 recapture after clear", cap_addr, 23'h00_0020);

        // R11 irq
        w_ie(8'h0C);
        step();
        chk("R11 erase-verify enables no irq", irq, 0);
        w_ie(8'h01);
        chk("R11 irq one cycle late", irq, 0);
        step();
        chk("R11 irq asserted", irq, 1);
        w_clr(8'h01);
        chk("R11 irq still high one cycle", irq, 1);
        step();
        chk("R11 irq drops", irq, 0);

        // random phase, compared every clock against the model
        w_ie(8'hD3);
        for (int i = 0; i < 4000; i++) begin
            rd_stb      = ($urandom_range(0, 3) == 0);
            ecc_sgl     = ($urandom_range(0, 5) == 0);
            ecc_dbl     = ($urandom_range(0, 9) == 0);
            rd_addr     = AW'($urandom);
            rd_data     = DW'($urandom);
            ee_pgm_fail = ($urandom_range(0, 30) == 0);
            ee_ers_fail = ($urandom_range(0, 30) == 0);
            prot_viol   = ($urandom_range(0, 30) == 0);
            st_clr      = ($urandom_range(0, 6) == 0);
            st_clr_mask = 8'($urandom);
            inj_wr      = ($urandom_range(0, 60) == 0);
            inj_wdata   = 8'($urandom);
            ie_wr       = ($urandom_range(0, 80) == 0);
            ie_wdata    = 8'($urandom);
            step();
        end
        rd_stb = 0; ecc_sgl = 0; ecc_dbl = 0; ee_pgm_fail = 0; ee_ers_fail = 0;
        prot_viol = 0; st_clr = 0; inj_wr = 0; ie_wr = 0;
        step();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule